// File: doc/BRIEF.md
# Pointer-Counter Transfer Channel

This block moves one word at a time between a serial peripheral and system memory without processor involvement. Software loads a buffer address into the pointer register and a word count into the counter register. Each time the peripheral raises its request, the channel performs exactly one memory transaction at the current pointer, then advances the pointer by one word and retires one count. Depending on the `IS_TX` parameter, a channel either writes peripheral receive data into memory or reads memory data for the peripheral's transmitter. A chip uses one instance per direction.

When the counter is zero, the channel reports end-of-buffer. That flag stays set and all requests are refused until software loads a nonzero count. An enable bit routes the flag onto a level interrupt output. Only one memory transaction is outstanding at a time. After each completion, the channel spends one cycle acknowledging the peripheral before it looks at the request line again, so a request that is still high from the previous word is never counted twice.

Top module: `pcd_chan`

## Requirements
- R1: After reset, the pointer and counter are zero, the interrupt enable is clear, `end_flag` is 1, `irq` is 0 and `mem_req` is 0.
- R2: A register write (`reg_we`=1) selects its target by `reg_sel`: 0 loads the pointer from `reg_wdata`, 1 loads the counter from `reg_wdata[CNT_W-1:0]`, 2 loads the interrupt enable from `reg_wdata[0]`, and 3 changes nothing.
- R3: While idle, a high `per_req` with a nonzero counter starts one transaction at the current pointer. A receive channel (`IS_TX`=0) writes (`mem_we`=1) the `per_rx_data` sampled at the start. A transmit channel reads (`mem_we`=0).
- R4: `mem_req` and `mem_addr` hold steady until `mem_ack`. Exactly one memory transaction is issued per request. `per_ack` is high for one cycle after completion, and `per_req` is sampled again only in the cycle after that.
- R5: Each completion decrements the counter by one and advances the pointer by DATA_W/8 bytes (2 by default), wrapping modulo 2^ADDR_W.
- R6: In a transmit channel, `per_tx_data` holds the `mem_rdata` returned with `mem_ack` while `per_ack` is high.
- R7: `end_flag` is 1 exactly when the counter is zero. While it is 1, requests start no transaction and leave the pointer and counter unchanged.
- R8: `irq` is a level equal to `end_flag` AND the interrupt enable.
- R9: Writing a nonzero count clears `end_flag` and re-enables transfers. A register write that lands in the same cycle as a completion wins for its own register, while the other register still takes its completion update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 pointer, 1 counter, 2 control) |
| reg_wdata | input | ADDR_W | Register write data |
| per_req | input | 1 | Peripheral request (data ready / register empty) |
| per_rx_data | input | DATA_W | Peripheral receive word |
| per_ack | output | 1 | One-cycle completion acknowledge to peripheral |
| per_tx_data | output | DATA_W | Word read from memory for the transmitter |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completion handshake |
| ptr_q | output | ADDR_W | Current pointer readback |
| cnt_q | output | CNT_W | Current counter readback |
| end_flag | output | 1 | End-of-buffer status |
| irq | output | 1 | Level interrupt |

## Verification
A software write to the pointer or the counter can land in the same cycle as the memory acknowledge that would update that register. The bench provokes this with a zero-latency memory model: it watches for `mem_req` at the falling edge and drives the register write at that same edge, so the write and `mem_ack` meet the same rising edge. It then checks that the written register holds the software value while the other register shows the completion update. The same sweep also loads the pointer near the top of the address space, so a wrap occurs while transfers are running.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pcd_regs.sv
module pcd_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              irq_en,
  output logic              cnt_nz
);
  import pcd_pkg::*;

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  function automatic logic [ADDR_W-1:0] ptr_advance(input logic [ADDR_W-1:0] p);
    return p + STEP_V;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_retire(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - CNT_W'(1);
  endfunction

  logic ptr_wr, cnt_wr, ctl_wr;
  assign ptr_wr = reg_we && (reg_sel == SEL_PTR);
  assign cnt_wr = reg_we && (reg_sel == SEL_CNT);
  assign ctl_wr = reg_we && (reg_sel == SEL_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      irq_en <= 1'b0;
    end else begin
      if (ptr_wr)         ptr_q <= reg_wdata;
      else if (xfer_done) ptr_q <= ptr_advance(ptr_q);
      if (cnt_wr)         cnt_q <= reg_wdata[CNT_W-1:0];
      else if (xfer_done) cnt_q <= cnt_retire(cnt_q);
      if (ctl_wr)         irq_en <= reg_wdata[0];
    end
  end

  assign cnt_nz = (cnt_q != '0);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !ptr_wr) |=> ptr_q == ADDR_W'($past(ptr_q) + STEP_V)); // R5
  AST_CNT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cnt_wr && cnt_nz) |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))); // R5
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(reg_wdata[CNT_W-1:0])); // R9
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_q == $past(reg_wdata)); // R2
endmodule

// File: rtl/pcd_seq.sv
module pcd_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_req,
  input  logic              cnt_nz,
  input  logic [ADDR_W-1:0] ptr_q,
  input  logic [DATA_W-1:0] per_rx_data,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              xfer_done,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_tx_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  import pcd_pkg::*;

  seq_state_e state, state_nx;
  logic       start;

  assign start     = (state == ST_IDLE) && per_req && cnt_nz;
  assign xfer_done = (state == ST_BUSY) && mem_ack;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start)     state_nx = ST_BUSY;
      ST_BUSY: if (mem_ack)   state_nx = ST_DONE;
      ST_DONE:                state_nx = ST_IDLE;
      default:                state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      per_tx_data <= '0;
    end else begin
      state <= state_nx;
      if (start) begin
        mem_addr  <= ptr_q;
        mem_wdata <= per_rx_data;
      end
      if (xfer_done) per_tx_data <= mem_rdata;
    end
  end

  assign mem_req = (state == ST_BUSY);
  assign per_ack = (state == ST_DONE);

  generate
    if (IS_TX) begin : g_tx
      assign mem_we = 1'b0;
    end else begin : g_rx
      assign mem_we = mem_req;
    end
  endgenerate

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req); // R4
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr)); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack && !mem_req); // R4
  AST_NO_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !cnt_nz) |=> !mem_req); // R7
endmodule

// File: rtl/pcd_status.sv
module pcd_status (
  input  logic cnt_nz,
  input  logic irq_en,
  output logic end_flag,
  output logic irq
);
  assign end_flag = !cnt_nz;
  assign irq      = end_flag && irq_en;
endmodule

// File: rtl/pcd_chan.sv
module pcd_chan #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_tx_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              end_flag,
  output logic              irq
);
  localparam int STEP = DATA_W / 8;

  logic xfer_done, irq_en, cnt_nz;

  pcd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .xfer_done(xfer_done), .ptr_q(ptr_q),
    .cnt_q(cnt_q), .irq_en(irq_en), .cnt_nz(cnt_nz)
  );

  pcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_TX(IS_TX)) u_seq (
    .clk(clk), .rst_n(rst_n), .per_req(per_req), .cnt_nz(cnt_nz),
    .ptr_q(ptr_q), .per_rx_data(per_rx_data), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .xfer_done(xfer_done), .per_ack(per_ack),
    .per_tx_data(per_tx_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  pcd_status u_status (
    .cnt_nz(cnt_nz), .irq_en(irq_en), .end_flag(end_flag), .irq(irq)
  );

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !(reg_we && reg_sel == 2'd1)) |=> end_flag); // R7
  AST_NO_REQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !mem_req) |=> !mem_req); // R7
endmodule

// File: tb/pcd_chan_test.sv
module pcd_mem_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_req,
  input  logic        mem_we,
  input  logic [15:0] mem_addr,
  input  logic [15:0] mem_wdata,
  input  logic [1:0]  lat,
  output logic [15:0] mem_rdata,
  output logic        mem_ack,
  output logic [15:0] last_waddr,
  output logic [15:0] last_wdata,
  output int          wr_count,
  output int          rd_count
);
  logic [1:0] dly;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; dly <= '0; mem_rdata <= '0;
      last_waddr <= '0; last_wdata <= '0; wr_count <= 0; rd_count <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; dly <= '0;
    end else if (mem_req) begin
      if (dly >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_addr ^ 16'h5A3C;
        if (mem_we) begin
          last_waddr <= mem_addr; last_wdata <= mem_wdata; wr_count <= wr_count + 1;
        end else rd_count <= rd_count + 1;
      end else dly <= dly + 2'd1;
    end
  end
endmodule

module pcd_chan_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;

  // receive side
  logic        r_we = 0; logic [1:0] r_sel = 0; logic [15:0] r_wd = 0;
  logic        r_req = 0; logic [15:0] r_rxd = 0;
  logic        r_pack, r_mreq, r_mwe, r_mack, r_end, r_irq;
  logic [15:0] r_txd, r_addr, r_mwd, r_mrd, r_ptr, r_waddr, r_wdata;
  logic [7:0]  r_cnt;
  logic [1:0]  r_lat = 0;
  int          r_wr, r_rd;

  // transmit side
  logic        t_we = 0; logic [1:0] t_sel = 0; logic [15:0] t_wd = 0;
  logic        t_req = 0;
  logic        t_pack, t_mreq, t_mwe, t_mack, t_end, t_irq;
  logic [15:0] t_txd, t_addr, t_mwd, t_mrd, t_ptr, t_waddr, t_wdata;
  logic [7:0]  t_cnt;
  logic [1:0]  t_lat = 0;
  int          t_wr, t_rd;

  pcd_chan #(.IS_TX(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(r_we), .reg_sel(r_sel), .reg_wdata(r_wd),
    .per_req(r_req), .per_rx_data(r_rxd), .per_ack(r_pack), .per_tx_data(r_txd),
    .mem_req(r_mreq), .mem_we(r_mwe), .mem_addr(r_addr), .mem_wdata(r_mwd),
    .mem_rdata(r_mrd), .mem_ack(r_mack), .ptr_q(r_ptr), .cnt_q(r_cnt),
    .end_flag(r_end), .irq(r_irq));

  pcd_mem_model u_rmem (.clk(clk), .rst_n(rst_n), .mem_req(r_mreq), .mem_we(r_mwe),
    .mem_addr(r_addr), .mem_wdata(r_mwd), .lat(r_lat), .mem_rdata(r_mrd),
    .mem_ack(r_mack), .last_waddr(r_waddr), .last_wdata(r_wdata),
    .wr_count(r_wr), .rd_count(r_rd));

  pcd_chan #(.IS_TX(1'b1)) uut_tx (
    .clk(clk), .rst_n(rst_n), .reg_we(t_we), .reg_sel(t_sel), .reg_wdata(t_wd),
    .per_req(t_req), .per_rx_data(16'h0000), .per_ack(t_pack), .per_tx_data(t_txd),
    .mem_req(t_mreq), .mem_we(t_mwe), .mem_addr(t_addr), .mem_wdata(t_mwd),
    .mem_rdata(t_mrd), .mem_ack(t_mack), .ptr_q(t_ptr), .cnt_q(t_cnt),
    .end_flag(t_end), .irq(t_irq));

  pcd_mem_model u_tmem (.clk(clk), .rst_n(rst_n), .mem_req(t_mreq), .mem_we(t_mwe),
    .mem_addr(t_addr), .mem_wdata(t_mwd), .lat(t_lat), .mem_rdata(t_mrd),
    .mem_ack(t_mack), .last_waddr(t_waddr), .last_wdata(t_wdata),
    .wr_count(t_wr), .rd_count(t_rd));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic wr_reg(input bit tx, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    if (tx) begin t_we = 1; t_sel = sel; t_wd = d; end
    else    begin r_we = 1; r_sel = sel; r_wd = d; end
    @(negedge clk);
    t_we = 0; r_we = 0;
  endtask

  // one request held until the channel acknowledges; returns at the DONE-cycle negedge
  task automatic xfer(input bit tx, input logic [15:0] d, output logic [15:0] txd);
    @(negedge clk);
    if (tx) t_req = 1; else begin r_req = 1; r_rxd = d; end
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tx ? t_pack : r_pack) break;
    end
    txd = t_txd;
    t_req = 0; r_req = 0;
  endtask

  int            seen_req;
  logic [15:0]   txd;
  logic [15:0]   exp_ptr;

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(r_ptr == 0 && r_cnt == 0, "R1 ptr/cnt", {r_ptr, 8'h0, r_cnt}, 0);
    check(r_end == 1 && r_irq == 0 && r_mreq == 0, "R1 flags", {r_end, r_irq, r_mreq}, 3'b100);

    // R7: requests at zero count are ignored
    seen_req = 0;
    r_req = 1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (r_mreq) seen_req++; end
    r_req = 0;
    check(seen_req == 0 && r_wr == 0 && r_ptr == 0, "R7 ignored at zero", seen_req, 0);

    // R2 loads, R9 nonzero clears end
    wr_reg(0, 2'd0, 16'h0100);
    wr_reg(0, 2'd1, 16'h0006);
    wr_reg(0, 2'd2, 16'h0001);
    check(r_ptr == 16'h0100 && r_cnt == 8'd6, "R2 ptr/cnt load", {r_ptr, 8'h0, r_cnt}, 32'h01000006);
    check(r_end == 0 && r_irq == 0, "R9 end cleared", {r_end, r_irq}, 0);
    wr_reg(0, 2'd3, 16'hFFFF);
    check(r_ptr == 16'h0100 && r_cnt == 8'd6 && r_irq == 0, "R2 select 3 ignored", {r_ptr, 8'h0, r_cnt}, 32'h01000006);

    // R3 R4 R5 receive sweep over memory latencies
    for (int k = 0; k < 6; k++) begin
      r_lat = 2'(k % 4);
      xfer(0, 16'(k * 16'h0131 + 7), txd);
      check(r_wr == k + 1, "R4 one write per request", r_wr, k + 1);
      check(r_waddr == 16'(16'h0100 + 2 * k), "R3 write address", r_waddr, 16'(16'h0100 + 2 * k));
      check(r_wdata == 16'(k * 16'h0131 + 7), "R3 write data", r_wdata, 16'(k * 16'h0131 + 7));
      check(r_cnt == 8'(5 - k) && r_ptr == 16'(16'h0102 + 2 * k), "R5 cnt/ptr update",
            {r_ptr, 8'h0, r_cnt}, {16'(16'h0102 + 2 * k), 8'h0, 8'(5 - k)});
      @(negedge clk);
      check(r_pack == 0, "R4 ack one cycle", r_pack, 0);
    end
    check(r_end == 1 && r_irq == 1, "R7 R8 end and irq", {r_end, r_irq}, 2'b11);

    // R7 requests after end ignored, R8 gating
    r_req = 1;
    seen_req = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (r_mreq) seen_req++; end
    r_req = 0;
    check(seen_req == 0 && r_wr == 6 && r_ptr == 16'h010C, "R7 no transfer at end", r_ptr, 16'h010C);
    wr_reg(0, 2'd2, 16'h0000);
    check(r_irq == 0 && r_end == 1, "R8 irq masked", {r_end, r_irq}, 2'b10);

    // R9 collision: counter write meets completion
    wr_reg(0, 2'd1, 16'h0003);
    r_lat = 0;
    exp_ptr = r_ptr + 16'd2;
    @(negedge clk);
    r_req = 1; r_rxd = 16'hBEEF;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (r_mreq) break; end
    r_we = 1; r_sel = 2'd1; r_wd = 16'h0009;
    @(negedge clk);
    r_we = 0; r_req = 0;
    check(r_cnt == 8'd9, "R9 counter write wins", r_cnt, 9);
    check(r_ptr == exp_ptr, "R9 pointer still advances", r_ptr, exp_ptr);

    // TX: wrap over top of address space
    wr_reg(1, 2'd0, 16'hFFFC);
    wr_reg(1, 2'd1, 16'h0003);
    wr_reg(1, 2'd2, 16'h0001);
    for (int k = 0; k < 3; k++) begin
      t_lat = 2'((k + 1) % 4);
      xfer(1, 16'h0, txd);
      check(txd == (16'(16'hFFFC + 2 * k) ^ 16'h5A3C), "R6 tx data", txd, 16'(16'hFFFC + 2 * k) ^ 16'h5A3C);
      check(t_ptr == 16'(16'hFFFE + 2 * k), "R5 pointer wrap", t_ptr, 16'(16'hFFFE + 2 * k));
    end
    check(t_wr == 0 && t_rd == 3, "R3 tx reads only", {t_wr[15:0], t_rd[15:0]}, 32'h00000003);
    check(t_end == 1 && t_irq == 1, "R8 tx irq", {t_end, t_irq}, 2'b11);

    // R9 collision: pointer write meets completion
    wr_reg(1, 2'd1, 16'h0004);
    check(t_end == 0 && t_irq == 0, "R9 reload clears end", {t_end, t_irq}, 0);
    t_lat = 0;
    @(negedge clk);
    t_req = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (t_mreq) break; end
    t_we = 1; t_sel = 2'd0; t_wd = 16'h2000;
    @(negedge clk);
    t_we = 0; t_req = 0;
    check(t_ptr == 16'h2000, "R9 pointer write wins", t_ptr, 16'h2000);
    check(t_cnt == 8'd3, "R9 counter still retires", t_cnt, 3);

    summary();
  end
endmodule